// File: doc/BRIEF.md
# Watchdog Kick and Enable Input Qualifier

This block sits between two asynchronous board-level inputs and the timeout logic of a watchdog. The inputs are the periodic "kick" that software toggles to show it is alive, and the enable level that switches the watchdog on and off. It brings both signals into the system clock domain through a two-flop synchronizer. It then refuses any new level until that level has stayed put for `FILT_CYCLES` consecutive clocks. Short glitches therefore vanish, while a real pulse of adequate length always gets through.

For the kick input, every accepted level change that counts as a trigger produces a single-cycle `kick_clr` pulse, which the timeout counter uses as its clear. The `both_edges` pin selects which changes count. When it is low, only low-to-high changes trigger. When it is high, changes in either direction trigger. The pin is a quasi-static strap and is only changed while the kick input is quiet.

For the enable input, the block outputs the qualified level `en_level`. Set `FILT_CYCLES` so that its period lies between the longest glitch to reject (about 100 ns) and the shortest pulse that must be accepted (about 1 µs). The value must be at least 2. At reset release, the block loads the first synchronized sample of each input directly as its starting level. A kick that is already high at power-up is therefore never seen as an edge, and timing needs no initial transition.

Top module: `wdg_kick_qualifier`

## Requirements
- R1: A kick level change held for at least `FILT_CYCLES` clocks drives `kick_clr` high in exactly the cycle after the (`FILT_CYCLES`+3)th rising clock edge, counting from the first edge at which the new level is present at the input. `kick_clr` is low in the cycles just before and just after.
- R2: Any change on either input that is held for `FILT_CYCLES` or more consecutive clock edges is accepted: a trigger for the kick input, and a new `en_level` for the enable input.
- R3: A kick pulse held for fewer than `FILT_CYCLES` clock edges produces no `kick_clr` in either mode, and neither does its return to the old level.
- R4: With `both_edges` = 0, a qualified 0→1 kick change gives one `kick_clr` pulse and a qualified 1→0 change gives none. The 1→0 change is still tracked, so the next qualified rise triggers.
- R5: With `both_edges` = 1, each qualified 0→1 change and each qualified 1→0 change of the kick input gives one `kick_clr` pulse.
- R6: `kick_clr` is exactly one clock wide and is never high in two consecutive cycles.
- R7: `en_level` uses the same qualification. An enable pulse shorter than `FILT_CYCLES` clocks never changes `en_level`. An accepted enable change appears after the (`FILT_CYCLES`+2)th rising edge, counting from the first edge at which the new level is present.
- R8: After reset release, the block loads the synchronized input levels without qualification. `en_level` shows the enable input level after the third rising edge. The kick level present at release never produces `kick_clr`.
- R9: While `rst_n` is low, `kick_clr` and `en_level` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_async | input | 1 | Asynchronous watchdog kick input |
| en_async | input | 1 | Asynchronous watchdog enable input |
| both_edges | input | 1 | Trigger mode: 0 = rising changes only, 1 = both directions |
| kick_clr | output | 1 | One-cycle clear pulse per accepted kick trigger |
| en_level | output | 1 | Qualified enable level |

## Verification
The bound checker watches several rules on every cycle. It confirms that no qualified level moves unless its synchronized sample has held the new value for at least `FILT_CYCLES` clocks. It confirms that every `kick_clr` follows a real change of the filtered kick level, that in rising-only mode the filtered level is high whenever `kick_clr` fires, that the pulse is never two cycles long, and that nothing fires during the post-reset load. Some properties depend on a sequence of stimulus, and only the bench scenarios can show them. These are the exact latency of a kick and of an enable change, the full accept/reject boundary across pulse widths and both polarities in both modes, and the number of pulses each stimulus produces. The same holds for the loading of the power-up levels, which the bench checks after reset with both inputs high.

// File: rtl/wkq_pkg.sv
package wkq_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_CH      = 2;
  localparam int CH_KICK     = 0;
  localparam int CH_EN       = 1;

  typedef enum logic {
    TRIG_RISE = 1'b0,
    TRIG_BOTH = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/wkq_sync.sv
// Multi-bit bank of independent single-bit synchronizers.
module wkq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wkq_warmup.sv
// Post-reset sequencer: load window while the synchronizer fills,
// then one settle cycle before edge reporting is armed.
module wkq_warmup #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic load,
  output logic arm
);
  localparam int LAST = STAGES + 2;
  localparam int CW   = $clog2(LAST + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (cnt != CW'(LAST))    cnt <= cnt + 1'b1;
  end

  assign load = (cnt <= CW'(STAGES));
  assign arm  = (cnt == CW'(LAST));
endmodule

// File: rtl/wkq_filter.sv
// Stability filter: output follows the sample only after the sample has
// differed from the output on CYCLES consecutive edges.
module wkq_filter #(
  parameter int CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic smp,
  output logic lvl
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt;
  logic          lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt   <= '0;
    end else if (load) begin
      lvl_q <= smp;
      cnt   <= '0;
    end else if (smp == lvl_q) begin
      cnt   <= '0;
    end else if (cnt == CW'(CYCLES - 1)) begin
      lvl_q <= smp;
      cnt   <= '0;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/wkq_trig.sv
// Edge selector: registered one-cycle pulse on a change of the filtered
// kick level that matches the trigger mode.
module wkq_trig
  import wkq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       lvl,
  input  trig_mode_e mode,
  output logic       clr
);
  logic prev_q;
  logic clr_q;
  logic changed;
  logic counts;

  assign changed = (lvl != prev_q);
  assign counts  = (mode == TRIG_BOTH) || lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      clr_q  <= arm && changed && counts;
    end
  end

  assign clr = clr_q;
endmodule

// File: rtl/wdg_kick_qualifier.sv
module wdg_kick_qualifier
  import wkq_pkg::*;
#(
  parameter int FILT_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_async,
  input  logic en_async,
  input  logic both_edges,
  output logic kick_clr,
  output logic en_level
);
  logic [NUM_CH-1:0] raw;
  logic [NUM_CH-1:0] smp;
  logic [NUM_CH-1:0] lvl;
  logic              load;
  logic              arm;
  logic              kick_smp;
  logic              en_smp;
  logic              kick_lvl;
  trig_mode_e        mode;

  assign raw[CH_KICK] = kick_async;
  assign raw[CH_EN]   = en_async;
  assign mode         = trig_mode_e'(both_edges);

  wkq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(smp)
  );

  wkq_warmup #(.STAGES(SYNC_STAGES)) warm_i (
    .clk(clk), .rst_n(rst_n), .load(load), .arm(arm)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wkq_filter #(.CYCLES(FILT_CYCLES)) filt_i (
      .clk(clk), .rst_n(rst_n), .load(load), .smp(smp[c]), .lvl(lvl[c])
    );
  end

  assign kick_smp = smp[CH_KICK];
  assign en_smp   = smp[CH_EN];
  assign kick_lvl = lvl[CH_KICK];

  wkq_trig trig_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .lvl(kick_lvl), .mode(mode),
    .clr(kick_clr)
  );

  assign en_level = lvl[CH_EN];
endmodule

// File: rtl/wkq_checker.sv
module wkq_checker #(
  parameter int FILT_CYCLES = 32
) (
  input logic clk,
  input logic rst_n,
  input logic both_edges,
  input logic kick_clr,
  input logic en_level,
  input logic kick_lvl,
  input logic kick_smp,
  input logic en_smp,
  input logic load,
  input logic arm
);
  localparam int RW = $clog2(FILT_CYCLES + 1);

  logic [RW-1:0] krun, erun;
  logic          kprev, eprev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      krun <= '0; erun <= '0; kprev <= 1'b0; eprev <= 1'b0;
    end else begin
      kprev <= kick_smp;
      eprev <= en_smp;
      if (kick_smp != kprev)              krun <= RW'(1);
      else if (krun != RW'(FILT_CYCLES))  krun <= krun + 1'b1;
      if (en_smp != eprev)                erun <= RW'(1);
      else if (erun != RW'(FILT_CYCLES))  erun <= erun + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!kick_clr && !en_level)); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    kick_clr |=> !kick_clr); // R6

  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!both_edges && kick_clr) |-> kick_lvl); // R4

  AST_CLR_HAS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    kick_clr |-> ($past(kick_lvl) != $past(kick_lvl, 2))); // R5

  AST_NO_CLR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !kick_clr); // R8

  AST_KICK_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && (kick_lvl != $past(kick_lvl)))
      |-> (krun >= RW'(FILT_CYCLES) && kprev == kick_lvl)); // R3

  AST_EN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && (en_level != $past(en_level)))
      |-> (erun >= RW'(FILT_CYCLES) && eprev == en_level)); // R7
endmodule

bind wdg_kick_qualifier wkq_checker #(.FILT_CYCLES(FILT_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .both_edges(both_edges), .kick_clr(kick_clr),
  .en_level(en_level), .kick_lvl(kick_lvl), .kick_smp(kick_smp),
  .en_smp(en_smp), .load(load), .arm(arm)
);

// File: tb/wdg_kick_qualifier_tb_top.sv
`timescale 1ns/1ps
module wdg_kick_qualifier_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0;
  logic en = 1'b0;
  logic both = 1'b0;
  logic kick_clr;
  logic en_level;

  int tests = 0;
  int fails = 0;
  int clr_cnt = 0;
  int dbl = 0;
  logic clr_prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdg_kick_qualifier #(.FILT_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .kick_async(kick), .en_async(en),
    .both_edges(both), .kick_clr(kick_clr), .en_level(en_level)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (kick_clr) clr_cnt++;
      if (kick_clr && clr_prev) dbl++;
      clr_prev = kick_clr;
    end else begin
      clr_prev = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic k, input logic e);
    @(negedge clk);
    rst_n = 1'b0; kick = k; en = e;
    idle(3);
    chk(kick_clr == 1'b0, "R9 kick_clr in reset", kick_clr, 0);
    chk(en_level == 1'b0, "R9 en_level in reset", en_level, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(en_level == 1'b0, "R8 en_level after 2 edges", en_level, 0);
    @(posedge clk); @(negedge clk);
    chk(en_level == e, "R8 en_level after 3 edges", en_level, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    int seen;
    int exp;
    string tag;

    // R8/R9: power-up with both inputs high
    do_reset(1'b1, 1'b1);
    c0 = clr_cnt;
    idle(20);
    chk(clr_cnt == c0, "R8 no kick_clr from power-up level", clr_cnt - c0, 0);
    do_reset(1'b0, 1'b0);
    idle(10);

    // R1: kick latency, rising-only mode
    both = 1'b0; kick = 1'b0; idle(N + 8);
    kick = 1'b1;
    for (int k = 1; k <= N + 4; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == N + 2) chk(kick_clr == 1'b0, "R1 before pulse", kick_clr, 0);
      if (k == N + 3) chk(kick_clr == 1'b1, "R1 pulse cycle", kick_clr, 1);
      if (k == N + 4) chk(kick_clr == 1'b0, "R1 after pulse", kick_clr, 0);
    end
    kick = 1'b0; idle(N + 8);

    // R2..R5: sweep pulse width, base polarity, mode
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 2; b++) begin
        for (int w = 1; w <= N + 3; w++) begin
          both = m[0]; kick = b[0];
          idle(N + 8);
          c0 = clr_cnt;
          kick = ~b[0];
          idle(w);
          kick = b[0];
          idle(N + 8);
          exp = (w >= N) ? 1 + m : 0;
          tag = (w < N) ? "R3 short kick" : (m == 1 ? "R5 both edges" : "R4 rise only");
          chk(clr_cnt - c0 == exp, tag, clr_cnt - c0, exp);
        end
      end
    end

    // R7: enable latency
    en = 1'b0; idle(N + 8);
    en = 1'b1;
    for (int k = 1; k <= N + 2; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == N + 1) chk(en_level == 1'b0, "R7 en before latency", en_level, 0);
      if (k == N + 2) chk(en_level == 1'b1, "R7 en at latency", en_level, 1);
    end
    en = 1'b0; idle(N + 8);
    chk(en_level == 1'b0, "R2 en accepted low", en_level, 0);

    // R2/R7: enable pulse width sweep
    for (int w = 1; w <= N + 3; w++) begin
      seen = 0;
      en = 1'b1;
      for (int i = 0; i < w; i++) begin @(negedge clk); if (en_level) seen = 1; end
      en = 1'b0;
      for (int i = 0; i < N + 8; i++) begin @(negedge clk); if (en_level) seen = 1; end
      exp = (w >= N) ? 1 : 0;
      tag = (w < N) ? "R7 en glitch rejected" : "R2 en pulse accepted";
      chk(seen == exp, tag, seen, exp);
    end

    chk(dbl == 0, "R6 kick_clr wider than one cycle", dbl, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule